// File: doc/BRIEF.md
# Event-Action PWM Waveform Generator

This block turns per-cycle timer events into one PWM level. A timer beside it raises six single-cycle strobes: the count reached zero, the count equals compare X while rising, equals compare Y while rising, reached the reload value, equals compare Y while falling, and equals compare X while falling. For each strobe, a 12-bit action word holds a 2-bit field that says how the output reacts. The output can be left alone, forced low, forced high or toggled.

Two instances with separate enables and separate action words make two channels. Both channels take their strobes from the same timer and the same pair of compare values. By choosing the actions, one channel can produce edge-aligned, center-aligned or asymmetric waveforms. The output is the raw level. Dead band, polarity and fault gating are applied further down the path.

Top module: `pwm_evt_wavegen`

## Requirements
- R1: While `rst_ni` is low, `pwm_o` is 0.
- R2: When `en_i` is sampled low at a clock edge, `pwm_o` is 0 after that edge, and no strobe or action word changes this.
- R3: Action code 2'b00 leaves `pwm_o` at its present level.
- R4: Action code 2'b01 sets `pwm_o` to 0.
- R5: Action code 2'b10 sets `pwm_o` to 1.
- R6: Action code 2'b11 sets `pwm_o` to the inverse of its present level.
- R7: Strobe bit k of `evt_i` uses the action held in `cfg_i[2k+1:2k]`. The bits map as follows: 0 is zero, 1 is compare X rising, 2 is compare Y rising, 3 is reload, 4 is compare Y falling, and 5 is compare X falling.
- R8: When several strobes are high in one cycle, only the action of the highest-numbered strobe is applied, even if that action is 2'b00.
- R9: `pwm_o` is registered. It changes only at the clock edge that samples a strobe, and it holds its level through any cycle in which no strobe is high.
- R10: After the channel is disabled and enabled again, the next action starts from level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| cfg_i | input | 12 | Six 2-bit action fields, strobe k at bits [2k+1:2k] |
| evt_i | input | 6 | Timer event strobes, one cycle wide each |
| pwm_o | output | 1 | Registered raw PWM level |

## Verification
Two strobes can fall in the same cycle. At the top or bottom of a period, zero or reload can coincide with a compare match, and a rising X match can coincide with a falling Y match. The bench provokes this by raising two strobes in one cycle with action words in which the two actions conflict. It first places the output in the level that the losing action would keep, so only the higher-numbered strobe's action can explain the result. A case where the winner is 2'b00 confirms that a lower strobe's action does not leak through.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int unsigned ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  function automatic logic next_level(act_e act, logic cur);
    unique case (act)
      ACT_NONE:   next_level = cur;
      ACT_LOW:    next_level = 1'b0;
      ACT_HIGH:   next_level = 1'b1;
      default:    next_level = ~cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_evt_prio.sv
module pwm_evt_prio #(
  parameter int unsigned NUM_EVT = 6
) (
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [NUM_EVT-1:0] win_o,
  output logic               any_o
);
  // hi[k]: some strobe at index >= k is set
  logic [NUM_EVT:0] hi;
  assign hi[NUM_EVT] = 1'b0;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_chain
    assign hi[k]    = hi[k+1] | evt_i[k];
    assign win_o[k] = evt_i[k] & ~hi[k+1];
  end

  assign any_o = hi[0];

  always_comb begin
    assert_single_winner_R8: assert ($onehot0(win_o));
    assert_winner_iff_any_R8: assert ((win_o != '0) == (evt_i != '0));
  end
endmodule

// File: rtl/pwm_act_mux.sv
module pwm_act_mux
  import pwm_evt_pkg::*;
#(
  parameter int unsigned NUM_EVT = 6,
  localparam int unsigned CFG_W  = NUM_EVT * ACT_W
) (
  input  logic [CFG_W-1:0]   cfg_i,
  input  logic [NUM_EVT-1:0] win_i,
  output act_e               act_o
);
  logic [NUM_EVT-1:0][ACT_W-1:0] masked;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_field
    assign masked[k] = {ACT_W{win_i[k]}} & cfg_i[k*ACT_W +: ACT_W];
  end

  always_comb begin
    logic [ACT_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_EVT; k++) acc = acc | masked[k];
    act_o = act_e'(acc);
  end
endmodule

// File: rtl/pwm_out_reg.sv
module pwm_out_reg
  import pwm_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic any_i,
  input  act_e act_i,
  output logic pwm_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= 1'b0;
    else if (!en_i)  lvl_q <= 1'b0;
    else if (any_i)  lvl_q <= next_level(act_i, lvl_q);
  end

  assign pwm_o = lvl_q;

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !any_i) |=> $stable(lvl_q));
  assert_disable_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !lvl_q);
endmodule

// File: rtl/pwm_evt_wavegen.sv
module pwm_evt_wavegen
  import pwm_evt_pkg::*;
#(
  parameter int unsigned NUM_EVT = 6,
  localparam int unsigned CFG_W  = NUM_EVT * ACT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [CFG_W-1:0]   cfg_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               pwm_o
);
  logic [NUM_EVT-1:0] win;
  logic               any_evt;
  act_e               act;

  pwm_evt_prio #(.NUM_EVT(NUM_EVT)) u_prio (
    .evt_i (evt_i),
    .win_o (win),
    .any_o (any_evt)
  );

  pwm_act_mux #(.NUM_EVT(NUM_EVT)) u_mux (
    .cfg_i (cfg_i),
    .win_i (win),
    .act_o (act)
  );

  pwm_out_reg u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .any_i (any_evt),
    .act_i (act),
    .pwm_o (pwm_o)
  );

  localparam int unsigned TOP = NUM_EVT - 1;

  assert_top_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i[TOP] && cfg_i[TOP*ACT_W +: ACT_W] == 2'b10) |=> pwm_o);
  assert_top_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i[TOP] && cfg_i[TOP*ACT_W +: ACT_W] == 2'b01) |=> !pwm_o);
  assert_top_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i[TOP] && cfg_i[TOP*ACT_W +: ACT_W] == 2'b11) |=> (pwm_o != $past(pwm_o)));
  assert_top_none_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i[TOP] && cfg_i[TOP*ACT_W +: ACT_W] == 2'b00) |=> $stable(pwm_o));
  assert_reset_low_R1: assert property (@(posedge clk_i) !rst_ni |-> !pwm_o);
endmodule

// File: tb/pwm_evt_wavegen_tb.sv
module pwm_evt_wavegen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [11:0] cfg_i = '0;
  logic [5:0]  evt_i = '0;
  logic        pwm_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pwm_evt_wavegen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .cfg_i(cfg_i), .evt_i(evt_i), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pwm_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] fld(input int k, input logic [1:0] a, input logic [11:0] base);
    logic [11:0] r;
    r = base;
    r[2*k +: 2] = a;
    return r;
  endfunction

  // drive strobes for one cycle, result checked at the following negedge
  task automatic pulse(input logic [5:0] e);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic force_level(input logic v);
    cfg_i = fld(3, v ? 2'b10 : 2'b01, 12'h000);
    pulse(6'b001000);
  endtask

  task automatic test_reset();
    chk("R1", pwm_o, 1'b0);
    repeat (2) @(negedge clk_i);
    chk("R1", pwm_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2", pwm_o, 1'b0);
  endtask

  task automatic test_fields();
    en_i = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 6; k++) begin
      // other fields set to low so a wrong field position shows up
      cfg_i = fld(k, 2'b10, 12'h555);
      pulse(6'b1 << k);
      chk($sformatf("R5 R7 evt%0d", k), pwm_o, 1'b1);
      cfg_i = fld(k, 2'b01, 12'hAAA);
      pulse(6'b1 << k);
      chk($sformatf("R4 R7 evt%0d", k), pwm_o, 1'b0);
      cfg_i = fld(k, 2'b11, 12'h000);
      pulse(6'b1 << k);
      chk($sformatf("R6 evt%0d", k), pwm_o, 1'b1);
      pulse(6'b1 << k);
      chk($sformatf("R6 evt%0d", k), pwm_o, 1'b0);
    end
  endtask

  task automatic test_none();
    force_level(1'b1);
    cfg_i = fld(0, 2'b00, 12'hAAA);
    pulse(6'b000001);
    chk("R3", pwm_o, 1'b1);
    force_level(1'b0);
    cfg_i = fld(4, 2'b00, 12'h555);
    pulse(6'b010000);
    chk("R3", pwm_o, 1'b0);
  endtask

  task automatic test_priority();
    force_level(1'b1);
    cfg_i = fld(5, 2'b01, fld(2, 2'b10, 12'h000));
    pulse(6'b100100);
    chk("R8 x-fall over y-rise", pwm_o, 1'b0);
    cfg_i = fld(5, 2'b10, fld(0, 2'b01, 12'h000));
    pulse(6'b100001);
    chk("R8 x-fall over zero", pwm_o, 1'b1);
    cfg_i = fld(5, 2'b00, fld(1, 2'b01, 12'h000));
    pulse(6'b100010);
    chk("R8 none wins", pwm_o, 1'b1);
    cfg_i = fld(3, 2'b01, fld(1, 2'b10, fld(0, 2'b10, 12'h000)));
    pulse(6'b001011);
    chk("R8 reload over three", pwm_o, 1'b0);
  endtask

  task automatic test_latency();
    force_level(1'b0);
    cfg_i = fld(1, 2'b10, 12'h000);
    evt_i = 6'b000010;
    #2;
    chk("R9 before edge", pwm_o, 1'b0);
    @(negedge clk_i);
    evt_i = '0;
    chk("R9 after edge", pwm_o, 1'b1);
    cfg_i = 12'h555;
    repeat (3) @(negedge clk_i);
    chk("R9 idle hold", pwm_o, 1'b1);
  endtask

  task automatic test_disable();
    force_level(1'b1);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R2 disable", pwm_o, 1'b0);
    cfg_i = 12'hAAA;
    pulse(6'b111111);
    chk("R2 strobes ignored", pwm_o, 1'b0);
    cfg_i = 12'hFFF;
    pulse(6'b000100);
    chk("R2 toggle ignored", pwm_o, 1'b0);
    en_i = 1'b1;
    cfg_i = fld(3, 2'b11, 12'h000);
    pulse(6'b001000);
    chk("R10 restart from low", pwm_o, 1'b1);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    test_reset();
    test_fields();
    test_none();
    test_priority();
    test_latency();
    test_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule